// File: doc/BRIEF.md
# Virtual Context Pointer Tracker

This block tracks a small set of virtual-machine control contexts for one logical processor. Each context is named by a 64-bit physical pointer. The tracker holds three kinds of state:

- which contexts are active;
- which single context, if any, is current;
- a per-context launch state, either "clear" or "launched".

The block takes one command per cycle. Each command has an opcode and a 64-bit operand, and the block answers one cycle later with a status. For store-pointer the answer also carries a pointer.

The active contexts live in a fixed-depth associative table, with the launch state stored beside each entry. The current context is held as an index into that table. Pointer operands are checked before use, against three rules:

- 4 KiB alignment;
- a configurable physical-address width;
- an optional 32-bit limit selected by a mode input.

An entry command is a launch or a resume. When the shadowing input is set on an entry command, its operand is a link pointer, and that context is made active on success.

Top module: `vctx_tracker`

## Requirements
- R1: A load-pointer, clear, or shadowed entry command whose pointer operand has any of bits 11:0 set is answered with status 2 (bad pointer) and changes no state.
- R2: A pointer operand with any bit at or above position PAW set (default PAW = 46) is answered with status 2 and changes no state.
- R3: With `lim32_mode` high, a pointer operand with any bit in 63:32 set is answered with status 2 and changes no state.
- R4: Load-pointer (opcode 0) with a valid pointer answers status 0 and makes that context active and current. Contexts that were active before stay active.
- R5: Clear (opcode 1) with a valid pointer answers status 0 and removes that context from the table, so its launch state is "clear" if it is loaded again. If it was current, no context is current afterwards. Clearing a pointer that is not active also answers status 0.
- R6: Launch (opcode 2) answers status 0 only when a current context exists and its launch state is "clear", and it then sets that state to "launched". Otherwise it answers status 1 (bad state).
- R7: Resume (opcode 3) answers status 0 only when a current context exists with launch state "launched", and otherwise answers status 1. It never changes a launch state.
- R8: Store-pointer (opcode 4) always answers status 0. `rsp_ptr` carries the current pointer, or 64'hFFFF_FFFF_FFFF_FFFF when no context is current.
- R9: An entry command with `cmd_shadow` high checks the state condition of R6 or R7 first, then validates its operand as a link pointer. On success the link context becomes active and the current context is unchanged.
- R10: A context that enters the table has launch state "clear". Loading a context that is already active keeps its stored launch state.
- R11: If a new pointer must be activated while all DEPTH entries are in use, the command answers status 3 (overflow) and changes no state.
- R12: Each command gets `rsp_valid` exactly one cycle after `cmd_valid`. `rsp_ptr` is zero for every command except store-pointer. Opcodes 5 to 7 answer status 1 and change nothing. Reset empties the table, leaves no current context and drops `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode: 0 load, 1 clear, 2 launch, 3 resume, 4 store |
| cmd_ptr | input | 64 | Pointer operand, or the link pointer on a shadowed entry command |
| cmd_shadow | input | 1 | Shadowing control for launch and resume |
| lim32_mode | input | 1 | Restrict pointers to the low 32 bits |
| rsp_valid | output | 1 | Response valid, one cycle after the command |
| rsp_status | output | 2 | 0 ok, 1 bad state, 2 bad pointer, 3 overflow |
| rsp_ptr | output | 64 | Current pointer for store-pointer, else zero |

## Verification
Every result, including the status, the stored pointer and the state update, is registered on the same clock edge that accepts the command. A response is therefore due exactly one cycle after its command. The bench drives each command on a falling edge and samples the response on the next falling edge. Its reference model predicts the response for that command and compares it on every clock, including idle and reset cycles, where `rsp_valid` must be low. The model has no pipeline, so any extra or missing register stage shows up as a miscompare.

// File: rtl/vctx_pkg.sv
package vctx_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_CLEAR  = 3'd1,
    OP_LAUNCH = 3'd2,
    OP_RESUME = 3'd3,
    OP_STORE  = 3'd4
  } vctx_op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_STATE = 2'd1,
    ST_PTR   = 2'd2,
    ST_FULL  = 2'd3
  } vctx_st_e;

  localparam logic [63:0] NO_CURRENT = 64'hFFFF_FFFF_FFFF_FFFF;
endpackage

// File: rtl/vctx_ptr_check.sv
// Pointer validity: 4 KiB alignment, address-width limit, optional 32-bit limit.
module vctx_ptr_check #(
  parameter int PAW = 46
) (
  input  logic [63:0] ptr,
  input  logic        lim32,
  output logic        ok
);
  localparam logic [63:0] HI_MASK = ~((64'd1 << PAW) - 64'd1);

  logic aligned, in_width, in_lim;

  assign aligned  = (ptr[11:0] == 12'd0);
  assign in_width = ((ptr & HI_MASK) == 64'd0);
  assign in_lim   = !(lim32 && (ptr[63:32] != 32'd0));
  assign ok       = aligned && in_width && in_lim;
endmodule

// File: rtl/vctx_table.sv
// Active-context table: tag storage, valid and launched flags per entry.
module vctx_table #(
  parameter int DEPTH = 4,
  parameter int TW    = 34,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] lk_tag,
  output logic          lk_hit,
  output logic [IW-1:0] lk_idx,
  output logic          fr_ok,
  output logic [IW-1:0] fr_idx,
  input  logic          ins_en,
  input  logic [IW-1:0] ins_idx,
  input  logic [TW-1:0] ins_tag,
  input  logic          inv_en,
  input  logic [IW-1:0] inv_idx,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [IW-1:0] rd_idx,
  output logic [TW-1:0] rd_tag,
  output logic          rd_launched
);
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] lnch;
  logic [TW-1:0]    tags [DEPTH];
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == lk_tag);
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i] && !lk_hit) begin
        lk_hit = 1'b1;
        lk_idx = IW'(i);
      end
    end
  end

  always_comb begin
    fr_ok  = 1'b0;
    fr_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !fr_ok) begin
        fr_ok  = 1'b1;
        fr_idx = IW'(i);
      end
    end
  end

  // Tag storage: single write port, no reset, RAM-style.
  always_ff @(posedge clk) begin
    if (ins_en) tags[ins_idx] <= ins_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      lnch <= '0;
    end else begin
      if (inv_en) begin
        vld[inv_idx]  <= 1'b0;
        lnch[inv_idx] <= 1'b0;
      end
      if (set_en) lnch[set_idx] <= 1'b1;
      if (ins_en) begin
        vld[ins_idx]  <= 1'b1;
        lnch[ins_idx] <= 1'b0;
      end
    end
  end

  assign rd_tag      = tags[rd_idx];
  assign rd_launched = lnch[rd_idx];
endmodule

// File: rtl/vctx_tracker.sv
module vctx_tracker #(
  parameter int DEPTH = 4,
  parameter int PAW   = 46
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [63:0] cmd_ptr,
  input  logic        cmd_shadow,
  input  logic        lim32_mode,
  output logic        rsp_valid,
  output logic [1:0]  rsp_status,
  output logic [63:0] rsp_ptr
);
  import vctx_pkg::*;

  localparam int TW = PAW - 12;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          ptr_ok;
  logic          hit, fr_ok;
  logic [IW-1:0] hit_idx, fr_idx;
  logic          ins_en, inv_en, set_en;
  logic [TW-1:0] cur_tag;
  logic          cur_lnch;
  logic          cur_vld, cur_vld_n;
  logic [IW-1:0] cur_idx, cur_idx_n;
  vctx_st_e      st_n;
  logic [63:0]   ptr_n, cur_full;

  vctx_ptr_check #(.PAW(PAW)) u_chk_ptr (
    .ptr   (cmd_ptr),
    .lim32 (lim32_mode),
    .ok    (ptr_ok)
  );

  vctx_table #(.DEPTH(DEPTH), .TW(TW), .IW(IW)) u_tab (
    .clk         (clk),
    .rst         (rst),
    .lk_tag      (cmd_ptr[PAW-1:12]),
    .lk_hit      (hit),
    .lk_idx      (hit_idx),
    .fr_ok       (fr_ok),
    .fr_idx      (fr_idx),
    .ins_en      (ins_en),
    .ins_idx     (fr_idx),
    .ins_tag     (cmd_ptr[PAW-1:12]),
    .inv_en      (inv_en),
    .inv_idx     (hit_idx),
    .set_en      (set_en),
    .set_idx     (cur_idx),
    .rd_idx      (cur_idx),
    .rd_tag      (cur_tag),
    .rd_launched (cur_lnch)
  );

  always_comb begin
    cur_full = '0;
    cur_full[PAW-1:12] = cur_tag;
  end

  // Single-cycle command decision.
  always_comb begin
    st_n      = ST_OK;
    ptr_n     = '0;
    ins_en    = 1'b0;
    inv_en    = 1'b0;
    set_en    = 1'b0;
    cur_vld_n = cur_vld;
    cur_idx_n = cur_idx;
    if (cmd_valid) begin
      case (cmd_op)
        OP_LOAD: begin
          if (!ptr_ok)     st_n = ST_PTR;
          else if (hit)    cur_idx_n = hit_idx;
          else if (!fr_ok) st_n = ST_FULL;
          else begin
            ins_en    = 1'b1;
            cur_idx_n = fr_idx;
          end
          if (st_n == ST_OK) cur_vld_n = 1'b1;
        end
        OP_CLEAR: begin
          if (!ptr_ok) st_n = ST_PTR;
          else if (hit) begin
            inv_en = 1'b1;
            if (cur_vld && (cur_idx == hit_idx)) cur_vld_n = 1'b0;
          end
        end
        OP_LAUNCH, OP_RESUME: begin
          if (!cur_vld || (cur_lnch != (cmd_op == OP_RESUME))) st_n = ST_STATE;
          else if (cmd_shadow) begin
            if (!ptr_ok)              st_n = ST_PTR;
            else if (!hit && !fr_ok)  st_n = ST_FULL;
            else if (!hit)            ins_en = 1'b1;
          end
          if (st_n == ST_OK && cmd_op == OP_LAUNCH) set_en = 1'b1;
        end
        OP_STORE: ptr_n = cur_vld ? cur_full : NO_CURRENT;
        default:  st_n = ST_STATE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_vld    <= 1'b0;
      cur_idx    <= '0;
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_ptr    <= '0;
    end else begin
      cur_vld    <= cur_vld_n;
      cur_idx    <= cur_idx_n;
      rsp_valid  <= cmd_valid;
      rsp_status <= st_n;
      rsp_ptr    <= ptr_n;
    end
  end
endmodule

// File: rtl/vctx_tracker_chk.sv
module vctx_tracker_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic [63:0] cmd_ptr,
  input logic        lim32_mode,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [63:0] rsp_ptr,
  input logic        cur_vld
);
  import vctx_pkg::*;

  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);

  a_r1_misaligned: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_op == OP_LOAD || cmd_op == OP_CLEAR) && (cmd_ptr[11:0] != 12'd0)
    |=> rsp_status == ST_PTR);

  a_r3_lim32: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_op == OP_LOAD || cmd_op == OP_CLEAR) && lim32_mode && (cmd_ptr[63:32] != 32'd0)
    |=> rsp_status == ST_PTR);

  a_r4_load_current: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_LOAD |=> (rsp_status != ST_OK) || cur_vld);

  a_r6_launch_nocur: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_LAUNCH && !cur_vld |=> rsp_status == ST_STATE);

  a_r8_store_none: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_STORE && !cur_vld |=> rsp_status == ST_OK && rsp_ptr == NO_CURRENT);

  a_r11_full_nochange: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status == ST_FULL |-> $stable(cur_vld));
endmodule

bind vctx_tracker vctx_tracker_chk u_vctx_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_ptr    (cmd_ptr),
  .lim32_mode (lim32_mode),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_ptr    (rsp_ptr),
  .cur_vld    (cur_vld)
);

// File: tb/vctx_tracker_tb_top.sv
module vctx_tracker_tb_top;
  localparam int DEPTH = 4;
  localparam int PAW   = 46;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [63:0] cmd_ptr = 64'd0;
  logic        cmd_shadow = 1'b0;
  logic        lim32_mode = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [63:0] rsp_ptr;

  always #4 clk = ~clk;

  vctx_tracker #(.DEPTH(DEPTH), .PAW(PAW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ptr(cmd_ptr),
    .cmd_shadow(cmd_shadow), .lim32_mode(lim32_mode),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_ptr(rsp_ptr)
  );

  // Reference model state
  logic [63:0] m_act[$];
  bit          m_lnch[logic [63:0]];
  bit          m_cur_v;
  logic [63:0] m_cur_p;

  // Expected response for the command presented on the previous edge
  bit          e_v;
  logic [1:0]  e_st;
  logic [63:0] e_p;
  string       e_tag = "R12";
  int nvec = 0;
  int nbad = 0;

  function automatic bit m_present(logic [63:0] p);
    foreach (m_act[i]) if (m_act[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_ptr_ok(logic [63:0] p, bit lim);
    return (p[11:0] == 12'd0) && ((p >> PAW) == 64'd0) && !(lim && p[63:32] != 32'd0);
  endfunction

  function automatic string m_ptr_tag(logic [63:0] p);
    if (p[11:0] != 12'd0) return "R1";
    if ((p >> PAW) != 64'd0) return "R2";
    return "R3";
  endfunction

  task automatic m_activate(logic [63:0] p);
    m_act.push_back(p);
    m_lnch[p] = 1'b0;
  endtask

  task automatic model(input logic [2:0] op, input logic [63:0] p, input bit sh, input bit lim);
    bit ok = m_ptr_ok(p, lim);
    e_v = 1'b1; e_st = 2'd0; e_p = 64'd0;
    case (op)
      3'd0: begin
        e_tag = "R4";
        if (!ok) begin e_st = 2'd2; e_tag = m_ptr_tag(p); end
        else if (m_present(p)) begin m_cur_v = 1; m_cur_p = p; e_tag = "R10"; end
        else if (m_act.size() == DEPTH) begin e_st = 2'd3; e_tag = "R11"; end
        else begin m_activate(p); m_cur_v = 1; m_cur_p = p; end
      end
      3'd1: begin
        e_tag = "R5";
        if (!ok) begin e_st = 2'd2; e_tag = m_ptr_tag(p); end
        else begin
          foreach (m_act[i]) if (m_act[i] == p) begin m_act.delete(i); break; end
          if (m_lnch.exists(p)) m_lnch.delete(p);
          if (m_cur_v && m_cur_p == p) m_cur_v = 0;
        end
      end
      3'd2, 3'd3: begin
        e_tag = (op == 3'd2) ? "R6" : "R7";
        if (!m_cur_v || (m_lnch[m_cur_p] != (op == 3'd3))) e_st = 2'd1;
        else begin
          if (sh) begin
            e_tag = "R9";
            if (!ok) e_st = 2'd2;
            else if (!m_present(p) && m_act.size() == DEPTH) e_st = 2'd3;
            else if (!m_present(p)) m_activate(p);
          end
          if (e_st == 2'd0 && op == 3'd2) m_lnch[m_cur_p] = 1'b1;
        end
      end
      3'd4: begin e_tag = "R8"; e_p = m_cur_v ? m_cur_p : 64'hFFFF_FFFF_FFFF_FFFF; end
      default: begin e_tag = "R12"; e_st = 2'd1; end
    endcase
  endtask

  task automatic compare();
    nvec++;
    if (rsp_valid !== e_v || (e_v && (rsp_status !== e_st || rsp_ptr !== e_p))) begin
      nbad++;
      $display("FAIL %s: valid/status/ptr act=%0b/%0d/%h exp=%0b/%0d/%h",
               e_tag, rsp_valid, rsp_status, rsp_ptr, e_v, e_st, e_p);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input logic [63:0] p,
                      input bit sh = 0, input bit lim = 0);
    @(negedge clk);
    compare();
    if (v) model(op, p, sh, lim);
    else begin e_v = 0; e_tag = "R12"; end
    cmd_valid = v; cmd_op = op; cmd_ptr = p; cmd_shadow = sh; lim32_mode = lim;
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    rst = 1'b1; cmd_valid = 1'b0;
    e_v = 0; e_tag = "R12";
    m_act.delete(); m_lnch.delete(); m_cur_v = 0;
    repeat (2) begin @(negedge clk); compare(); end
    rst = 1'b0;
  endtask

  localparam logic [63:0] A = 64'h1000, B = 64'h2000, C = 64'h3000;
  localparam logic [63:0] D = 64'h4000, E = 64'h5000, F = 64'h6000;

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    m_cur_v = 0; e_v = 0;
    do_reset();
    step(0, 0, 0);                        // R12 idle after reset
    step(1, 3'd4, 0);                     // R8 no current
    step(1, 3'd2, 0);                     // R6 no current
    step(1, 3'd3, 0);                     // R7 no current
    step(1, 3'd0, 64'h1010);              // R1
    step(1, 3'd0, 64'd1 << PAW);          // R2
    step(1, 3'd0, 64'h1_0000_0000, 0, 1); // R3
    step(1, 3'd0, 64'h2000, 0, 1);        // R3 low pointer passes
    step(1, 3'd0, A);                     // R4
    step(1, 3'd4, 0);                     // R8 returns A
    step(1, 3'd3, 0);                     // R7 clear -> fail
    step(1, 3'd2, 0);                     // R6 ok
    step(1, 3'd2, 0);                     // R6 already launched
    step(1, 3'd3, 0);                     // R7 ok
    step(0, 0, 0);
    step(1, 3'd3, 0);                     // R7 still launched
    step(1, 3'd0, B);                     // R10 existing B stays clear
    step(1, 3'd3, 0);
    step(1, 3'd0, A);                     // R10 keeps launched
    step(1, 3'd3, 0);
    step(1, 3'd1, A);                     // R5 clear current
    step(1, 3'd4, 0);
    step(1, 3'd2, 0);
    step(1, 3'd0, A);
    step(1, 3'd2, 0);                     // R5 launch state back to clear
    step(1, 3'd0, C);
    step(1, 3'd0, D);
    step(1, 3'd0, E);                     // R11 overflow
    step(1, 3'd4, 0);                     // current still D
    step(1, 3'd1, B);
    step(1, 3'd0, E);
    step(1, 3'd2, 64'h7008, 1);           // R9 bad link
    step(1, 3'd2, F, 1);                  // R9 / R11 full
    step(1, 3'd2, A, 1);                  // R9 link already active
    step(1, 3'd4, 0);                     // current unchanged E
    step(1, 3'd1, C);
    step(1, 3'd3, F, 1);                  // R9 activates F
    step(1, 3'd4, 0);
    step(1, 3'd0, F);
    step(1, 3'd2, 0);                     // R10 new link clear
    step(1, 3'd0, E);
    step(1, 3'd3, 0);
    step(1, 3'd5, A);                     // R12 reserved
    step(1, 3'd7, A);
    step(1, 3'd1, 64'h1004);              // R1 on clear
    step(1, 3'd1, 64'h9000);              // R5 not active
    do_reset();
    step(1, 3'd4, 0);                     // R12 reset clears current
    step(1, 3'd0, A);
    step(1, 3'd2, 0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] pool [8] = '{A, B, C, D, E, F, 64'h1010, 64'h8000_0000_0000};
      bit v = ($urandom % 5) != 0;
      step(v, 3'($urandom % 8), pool[$urandom % 8], 1'($urandom % 2), 1'($urandom % 4 == 0));
    end
    step(0, 0, 0);
    step(0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule